// File: doc/BRIEF.md
# Performance-Level Transition Controller

This block holds a table of eight performance-level descriptors and one requested level per core. It picks the level to apply and runs a timed transition toward it. Software fills the descriptor table and the per-core request registers over a simple 32-bit register bus. The block takes the fastest level that any core asks for and clamps it against a software limit. While control is enabled and the chosen level differs from the one in force, it runs a fixed-length transition.

Level 0 is the fastest level, and higher indices are slower. Each descriptor word packs several fields: the memory-timing tuning codes, three clock dividers, a voltage code that counts down in 12.5 mV steps below 1.55 V, and a frequency in 20 MHz units. The block does not interpret these fields. It passes the descriptor of the level in force, with its index, to a downstream clock and voltage stage.

Each completed transition sets a write-one-to-clear pending flag, but only when both the event enable and the interrupt enable are set. The interrupt output follows that flag.

Top module: `dvfs_pstate_ctrl`

## Requirements
- R1: After reset the following hold:
  - The applied level is 0 and the status valid flag is 1, so the status word reads 0x100.
  - The limit register reads 7.
  - The enable, event-enable and interrupt-enable bits are all 0.
  - `irq` is 0.
- R2: Descriptor `i` sits at byte offset 0x064+4*i for i in 0..7 and reads back as written. `lvl_desc` always equals the descriptor of the level given on `lvl_idx`.
- R3: Bit 0 of the control word at 0x060 gates transitions.
  - While that bit is 0, request writes are stored but no transition starts.
  - Setting the bit starts any pending transition.
- R4: A request index greater than the limit register (0x0A0, bits [2:0]) is replaced by the limit value before the level is chosen.
- R5: Among all cores, after clamping, the numerically lowest requested index is the one applied.
- R6: A transition starts on the cycle after a write that makes the chosen level differ from the current one. The applied level changes exactly XITION_CYCLES+1 clock cycles after that write. Until then, the status valid bit is 0 and the current field keeps the old level.
- R7: The status word at 0x0A4 and each per-core word at 0x090+4*c use the same upper fields.
  - Status word: bits [2:0] hold the clamped chosen index, bits [6:4] the current level, and bit 8 the valid flag.
  - Per-core word: bits [2:0] hold that core's raw request, with the same bits [6:4] and bit 8.
- R8: A completed transition sets the pending bit (0x0D8, bit 0) only when bit 0 of 0x0D0 and bit 0 of 0x0D4 are both 1. `irq` equals the pending bit.
- R9: Writing 1 to bit 0 of 0x0D8 clears the pending bit. Writing 0 leaves it unchanged.
- R10: When the chosen level already equals the current level, no transition runs and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt, equal to the pending bit |
| lvl_idx | output | 3 | Index of the level in force |
| lvl_desc | output | 32 | Descriptor of the level in force |

## Verification
The bench checks that a request written while control is disabled is stored and does not move the applied level. A design that ignored the gate would shift the level early. Clamping and fastest-wins selection are tested with mixed requests across the cores. A controller that took the last writer's request, or skipped the limit, would apply the wrong index, and the scoreboard compares each applied level against its queue. Transition latency is measured from the triggering write, and the valid flag is read mid-transition, which catches an off-by-one delay or an early update of the current field. Each enable is dropped in turn to show that the pending flag needs both, a write of 0 is shown to leave pending set, and a repeat of the same level is shown to raise no event.

// File: rtl/dvfs_pstate_ctrl.sv
module dvfs_pstate_ctrl #(
  parameter int NUM_CORES     = 4,
  parameter int XITION_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [2:0]  lvl_idx,
  output logic [31:0] lvl_desc
);
  localparam int NLVL = 8;
  localparam int CW   = $clog2(XITION_CYCLES + 1);
  localparam logic [11:0] A_CTRL  = 12'h060;
  localparam logic [11:0] A_DESC  = 12'h064;
  localparam logic [11:0] A_CORE  = 12'h090;
  localparam logic [11:0] A_LIMIT = 12'h0A0;
  localparam logic [11:0] A_STAT  = 12'h0A4;
  localparam logic [11:0] A_EVEN  = 12'h0D0;
  localparam logic [11:0] A_IREN  = 12'h0D4;
  localparam logic [11:0] A_PEND  = 12'h0D8;

  logic          en, evt_en, irq_en, pend, busy;
  logic [31:0]   desc [NLVL];
  logic [2:0]    req  [NUM_CORES];
  logic [2:0]    limit, cur, dest, tgt;
  logic [CW-1:0] cnt;
  logic          done, start;

  always_comb begin
    tgt = 3'd7;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (req[c] > limit) begin
        if (limit < tgt) tgt = limit;
      end else if (req[c] < tgt) begin
        tgt = req[c];
      end
    end
  end

  assign done  = busy && (cnt == '0);
  assign start = !busy && en && (tgt != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      evt_en <= 1'b0;
      irq_en <= 1'b0;
      limit  <= 3'd7;
      for (int i = 0; i < NLVL; i++) desc[i] <= '0;
      for (int c = 0; c < NUM_CORES; c++) req[c] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL)  en     <= reg_wdata[0];
      if (reg_addr == A_EVEN)  evt_en <= reg_wdata[0];
      if (reg_addr == A_IREN)  irq_en <= reg_wdata[0];
      if (reg_addr == A_LIMIT) limit  <= reg_wdata[2:0];
      for (int i = 0; i < NLVL; i++)
        if (reg_addr == A_DESC + 12'(4 * i)) desc[i] <= reg_wdata;
      for (int c = 0; c < NUM_CORES; c++)
        if (reg_addr == A_CORE + 12'(4 * c)) req[c] <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      dest <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      dest <= tgt;
      cnt  <= CW'(XITION_CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
      cur  <= dest;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pend <= 1'b0;
    else if (done && evt_en && irq_en)        pend <= 1'b1;
    else if (reg_wr && reg_addr == A_PEND && reg_wdata[0]) pend <= 1'b0;
  end

  logic [31:0] upper;
  assign upper = {23'd0, !busy, 1'b0, cur, 4'd0};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'd0, en};
      A_LIMIT: reg_rdata = {29'd0, limit};
      A_STAT:  reg_rdata = upper | {29'd0, tgt};
      A_EVEN:  reg_rdata = {31'd0, evt_en};
      A_IREN:  reg_rdata = {31'd0, irq_en};
      A_PEND:  reg_rdata = {31'd0, pend};
      default: ;
    endcase
    for (int i = 0; i < NLVL; i++)
      if (reg_addr == A_DESC + 12'(4 * i)) reg_rdata = desc[i];
    for (int c = 0; c < NUM_CORES; c++)
      if (reg_addr == A_CORE + 12'(4 * c)) reg_rdata = upper | {29'd0, req[c]};
  end

  assign irq      = pend;
  assign lvl_idx  = cur;
  assign lvl_desc = desc[cur];
endmodule

module dvfs_pstate_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic [2:0]  lvl_idx,
  input logic        busy,
  input logic        en,
  input logic        evt_en,
  input logic        irq_en,
  input logic        done,
  input logic [2:0]  tgt,
  input logic [2:0]  limit
);
  p_idx_moves_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_idx) |-> $past(busy));
  p_start_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  p_target_within_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt <= limit);
  p_irq_needs_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_en && irq_en));
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 12'h0D8 && reg_wdata[0] && !done) |=> !irq);
endmodule

bind dvfs_pstate_ctrl dvfs_pstate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .lvl_idx(lvl_idx), .busy(busy),
  .en(en), .evt_en(evt_en), .irq_en(irq_en), .done(done), .tgt(tgt),
  .limit(limit)
);

// File: tb/sim_dvfs_pstate_ctrl.sv
module sim_dvfs_pstate_ctrl;
  localparam int NC = 4;
  localparam int TR = 5;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, lvl_desc;
  logic irq;
  logic [2:0] lvl_idx;

  dvfs_pstate_ctrl #(.NUM_CORES(NC), .XITION_CYCLES(TR)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, wcyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [2:0] idx; int at; } exp_t;
  exp_t q[$];
  logic [2:0] last_idx = '0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 wcyc = cyc;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_lvl(input logic [2:0] i);
    exp_t e;
    e.idx = i; e.at = wcyc;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] dval(input int i);
    return 32'h1000_0000 * (i + 1) + 32'h0000_0101 * i;
  endfunction

  always @(negedge clk) begin
    if (mon_on && lvl_idx !== last_idx) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected level change", {29'd0, lvl_idx}, {29'd0, last_idx});
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(lvl_idx == e.idx, "R5 applied level", {29'd0, lvl_idx}, {29'd0, e.idx});
        chk(cyc - e.at == TR + 1, "R6 transition latency", cyc - e.at, TR + 1);
        chk(lvl_desc == dval(int'(lvl_idx)), "R2 descriptor output", lvl_desc, dval(int'(lvl_idx)));
      end
      last_idx = lvl_idx;
    end
  end

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(12'h0A4, d); chk(d == 32'h100, "R1 status reset", d, 32'h100);
    rd(12'h0A0, d); chk(d == 32'd7, "R1 limit reset", d, 7);
    rd(12'h060, d); chk(d == 32'd0, "R1 enable reset", d, 0);
    chk(irq == 0 && lvl_idx == 0, "R1 irq/level reset", {28'd0, irq, lvl_idx}, 0);
    mon_on = 1;
    for (int i = 0; i < 8; i++) wr(12'h064 + 12'(4 * i), dval(i));
    rd(12'h070, d); chk(d == dval(3), "R2 descriptor readback", d, dval(3));
    chk(lvl_desc == dval(0), "R2 descriptor of level 0", lvl_desc, dval(0));

    // R3 gate closed: requests stored, nothing moves
    for (int c = 0; c < NC; c++) wr(12'h090 + 12'(4 * c), 32'd3);
    wait_cyc(15);
    chk(lvl_idx == 0, "R3 no move while disabled", {29'd0, lvl_idx}, 0);
    rd(12'h090, d); chk(d == 32'h103, "R3 request stored (R7 core word)", d, 32'h103);
    wr(12'h0D0, 1); wr(12'h0D4, 1);
    wr(12'h060, 1); expect_lvl(3);
    rd(12'h0A4, d); chk(d == 32'h003, "R6 valid low mid-transition", d, 32'h003);
    wait_cyc(12);
    rd(12'h0A4, d); chk(d == 32'h133, "R7 status after move", d, 32'h133);
    chk(irq == 1, "R8 irq on completion", {31'd0, irq}, 1);
    // R9 write-one-to-clear
    wr(12'h0D8, 0); chk(irq == 1, "R9 zero write keeps pending", {31'd0, irq}, 1);
    wr(12'h0D8, 1); chk(irq == 0, "R9 clear by one", {31'd0, irq}, 0);

    // R5 fastest wins
    wr(12'h090, 5);
    wr(12'h094, 2); expect_lvl(2);
    wr(12'h098, 6);
    wr(12'h09C, 4);
    wait_cyc(12);
    chk(lvl_idx == 2, "R5 lowest index applied", {29'd0, lvl_idx}, 2);
    wr(12'h0D8, 1);

    // R4 clamp
    wr(12'h060, 0);
    for (int c = 0; c < NC; c++) wr(12'h090 + 12'(4 * c), 32'd6);
    wr(12'h0A0, 4);
    rd(12'h0A4, d); chk(d == 32'h124, "R4 clamped target in status", d, 32'h124);
    wr(12'h060, 1); expect_lvl(4);
    wait_cyc(12);
    chk(lvl_idx == 4, "R4 clamped level applied", {29'd0, lvl_idx}, 4);
    wr(12'h0D8, 1);

    // R8 gating by each enable
    wr(12'h0D4, 0);
    wr(12'h0A0, 7); expect_lvl(6);
    wait_cyc(12);
    rd(12'h0D8, d); chk(d == 0 && irq == 0, "R8 no pending without irq enable", d, 0);
    wr(12'h0D0, 0); wr(12'h0D4, 1);
    wr(12'h090, 1); expect_lvl(1);
    for (int c = 1; c < NC; c++) wr(12'h090 + 12'(4 * c), 32'd1);
    wait_cyc(12);
    rd(12'h0D8, d); chk(d == 0 && irq == 0, "R8 no pending without event enable", d, 0);
    chk(lvl_idx == 1, "R8 level still moved", {29'd0, lvl_idx}, 1);

    // R10 same level: nothing happens
    wr(12'h0D0, 1);
    wr(12'h090, 1);
    wait_cyc(12);
    rd(12'h0D8, d); chk(d == 0, "R10 no event on same level", d, 0);
    rd(12'h0A4, d); chk(d == 32'h111, "R10 status unchanged", d, 32'h111);
    chk(q.size() == 0, "R6 all expected levels seen", q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule